// File: doc/BRIEF.md
# Fault-aware look-ahead route unit for a 3D mesh router

This unit sits behind one input port of a seven-port 3D mesh router. Its ports are local, east (+X), west (-X), north (+Y), south (-Y), up (+Z) and down (-Z). Each head flit arrives carrying an output port that the previous router already chose for this node. The unit checks that port against the link-fault status of this node and of the neighbour the port leads to. It keeps the port when it is safe. Otherwise it recomputes a route locally, preferring minimal directions.

Once the local output is settled, the unit works out which port the flit will need at the next node. It uses that neighbour's fault vector to do so and writes the answer back into the head flit. Body and tail flits follow the port held for their packet. Results appear one clock after the flit is presented.

Top module: `la_route_unit`

## Requirements
- R1: While rst_ni is low and after its release, out_valid_o, misroute_o and out_port_o are 0 until a valid flit is accepted.
- R2: The flit type is held in bits [33:32]. The codes are 01 head, 00 body, 10 tail and 11 single-flit packet. Head and single flits are routed. A routed flit whose destination equals the current node leaves on port 0 (local), and its next-port field is 0.
- R3: A routed flit carries a next-port field in bits [31:29] and a destination X, Y and Z in bits [28:27], [26:25] and [24:23]. Port codes are 0 local, 1 east, 2 west, 3 north, 4 south, 5 up and 6 down. Link-fault bit i belongs to port i+1. The carried port is kept when four conditions hold: it is in 1..6, it does not leave the 4x4x4 mesh, its local link is healthy, and the neighbour it reaches does not lead to a dead end. A neighbour is a dead end when it is not the destination and every minimal direction from it is marked faulty in its own vector. The vector for the neighbour behind port p is nbr_fault_i[6(p-1)+5:6(p-1)].
- R4: When the carried port is rejected, the unit picks the first minimal, healthy, non-dead-end direction in the order X, then Y, then Z.
- R5: Failing R4, the unit takes the first minimal healthy direction and ignores the neighbour. Failing that, it takes the lowest-numbered healthy in-mesh non-minimal direction. If no link is healthy, it takes the first minimal direction.
- R6: misroute_o is 1 exactly when a routed flit leaves on a direction port that does not bring it closer to its destination.
- R7: The next-port field of a routed output flit is computed for the node reached through the chosen port, using that neighbour's fault vector. It is 0 if that node is the destination. Otherwise it is the first minimal healthy direction, then the lowest healthy in-mesh non-minimal direction, then the first minimal direction. All other flit bits pass unchanged.
- R8: Body and tail flits pass unchanged on the port held from the last head flit, with misroute_o at 0. A tail flit releases the hold to port 0. Single flits and invalid cycles leave the hold untouched.
- R9: out_valid_o equals flit_valid_i one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flit_valid_i | input | 1 | Flit present on flit_i |
| flit_i | input | 34 | Incoming flit |
| cur_x_i | input | 2 | X coordinate of this node |
| cur_y_i | input | 2 | Y coordinate of this node |
| cur_z_i | input | 2 | Z coordinate of this node |
| link_fault_i | input | 6 | Fault flags of this node's six links |
| nbr_fault_i | input | 36 | Fault vectors of the six neighbours, 6 bits each |
| out_valid_o | output | 1 | Output flit valid |
| out_port_o | output | 3 | Selected local output port |
| flit_o | output | 34 | Flit with updated next-port field |
| misroute_o | output | 1 | Non-minimal direction chosen |

## Verification
On every cycle, the assertions check the one-cycle valid timing and that arrival at the destination yields the local port. They also check that body and tail flits pass unmodified, that a misroute flag never accompanies the local port, and that a healthy link is chosen whenever one exists. The exact choice among candidate ports is shown only by the bench's sweeps. These cover the keep-versus-recompute decision, the X-Y-Z priority, the dead-end neighbour rule, the fallbacks and the next-hop field over every source and destination pair under several fault maps. The packet hold and its release on a tail are shown only by the bench's packet sequence.

// File: rtl/la_route_pkg.sv
package la_route_pkg;
  localparam int CW   = 2;
  localparam int NDIR = 6;
  localparam int PW   = 3;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [PW-1:0] PORT_LOCAL = '0;

  typedef struct packed {
    logic [CW-1:0] z;
    logic [CW-1:0] y;
    logic [CW-1:0] x;
  } coord_t;

  typedef enum logic [1:0] {
    FT_BODY   = 2'b00,
    FT_HEAD   = 2'b01,
    FT_TAIL   = 2'b10,
    FT_SINGLE = 2'b11
  } ftype_e;

  // bit 2a: +axis, bit 2a+1: -axis; axis 0=X,1=Y,2=Z
  function automatic logic [NDIR-1:0] min_dirs(coord_t c, coord_t d);
    logic [NDIR-1:0] m;
    for (int a = 0; a < 3; a++) begin
      m[2*a]   = d[CW*a +: CW] > c[CW*a +: CW];
      m[2*a+1] = d[CW*a +: CW] < c[CW*a +: CW];
    end
    return m;
  endfunction

  function automatic logic [NDIR-1:0] in_mesh_dirs(coord_t c);
    logic [NDIR-1:0] m;
    for (int a = 0; a < 3; a++) begin
      m[2*a]   = c[CW*a +: CW] != CMAX;
      m[2*a+1] = c[CW*a +: CW] != '0;
    end
    return m;
  endfunction

  function automatic coord_t step(coord_t c, logic [PW-1:0] p);
    coord_t n;
    n = c;
    case (p)
      3'd1: n.x = c.x + 1'b1;
      3'd2: n.x = c.x - 1'b1;
      3'd3: n.y = c.y + 1'b1;
      3'd4: n.y = c.y - 1'b1;
      3'd5: n.z = c.z + 1'b1;
      3'd6: n.z = c.z - 1'b1;
      default: n = c;
    endcase
    return n;
  endfunction

  function automatic logic [PW-1:0] first_port(logic [NDIR-1:0] m);
    logic [PW-1:0] p;
    p = PORT_LOCAL;
    for (int i = NDIR-1; i >= 0; i--)
      if (m[i]) p = PW'(i+1);
    return p;
  endfunction

  function automatic logic [NDIR-1:0] port_oh(logic [PW-1:0] p);
    logic [NDIR-1:0] o;
    for (int i = 0; i < NDIR; i++) o[i] = (p == PW'(i+1));
    return o;
  endfunction
endpackage

// File: rtl/la_dead_end.sv
module la_dead_end
  import la_route_pkg::*;
(
  input  coord_t                 cur_i,
  input  coord_t                 dst_i,
  input  logic [NDIR*NDIR-1:0]   nbr_fault_i,
  output logic [NDIR-1:0]        dead_o
);
  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    coord_t nb;
    assign nb        = step(cur_i, PW'(g+1));
    assign dead_o[g] = (nb != dst_i) &&
                       ((min_dirs(nb, dst_i) & ~nbr_fault_i[g*NDIR +: NDIR]) == '0);
  end
endmodule

// File: rtl/la_route_select.sv
module la_route_select
  import la_route_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  coord_t          cur_i,
  input  coord_t          dst_i,
  input  logic [PW-1:0]   carried_i,
  input  logic [NDIR-1:0] fault_i,
  input  logic [NDIR-1:0] dead_i,
  output logic [PW-1:0]   port_o,
  output logic            misroute_o
);
  logic            at_dest, carried_ok;
  logic [NDIR-1:0] mm, healthy, c1, c2, c3, sel_oh;

  always_comb begin
    at_dest    = (cur_i == dst_i);
    mm         = min_dirs(cur_i, dst_i);
    healthy    = ~fault_i & in_mesh_dirs(cur_i);
    carried_ok = |(port_oh(carried_i) & healthy & ~dead_i);
    c1 = mm & healthy & ~dead_i;
    c2 = mm & healthy;
    c3 = ~mm & healthy;
    if (at_dest)         port_o = PORT_LOCAL;
    else if (carried_ok) port_o = carried_i;
    else if (|c1)        port_o = first_port(c1);
    else if (|c2)        port_o = first_port(c2);
    else if (|c3)        port_o = first_port(c3);
    else                 port_o = first_port(mm);
    sel_oh     = port_oh(port_o);
    misroute_o = |(sel_oh & ~mm);
  end

  // R4: a healthy link is used whenever one exists
  a_r4_healthy_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_dest && |healthy) |-> |(sel_oh & healthy));

  // R5: with no minimal healthy link and no kept port, a detour is flagged
  a_r5_detour_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_dest && !carried_ok && c2 == '0 && |c3) |-> misroute_o);
endmodule

// File: rtl/la_next_hop.sv
module la_next_hop
  import la_route_pkg::*;
(
  input  coord_t                 cur_i,
  input  coord_t                 dst_i,
  input  logic [PW-1:0]          port_i,
  input  logic [NDIR*NDIR-1:0]   nbr_fault_i,
  output logic [PW-1:0]          next_o
);
  coord_t          nb;
  logic [NDIR-1:0] nf, nm, ok_min, ok_non;

  always_comb begin
    nb = step(cur_i, port_i);
    nf = '0;
    for (int i = 0; i < NDIR; i++)
      if (port_i == PW'(i+1)) nf = nbr_fault_i[i*NDIR +: NDIR];
    nm     = min_dirs(nb, dst_i);
    ok_min = nm & ~nf;
    ok_non = ~nm & ~nf & in_mesh_dirs(nb);
    if (port_i == PORT_LOCAL || nb == dst_i) next_o = PORT_LOCAL;
    else if (|ok_min)                         next_o = first_port(ok_min);
    else if (|ok_non)                         next_o = first_port(ok_non);
    else                                      next_o = first_port(nm);
  end
endmodule

// File: rtl/la_route_unit.sv
module la_route_unit
  import la_route_pkg::*;
#(
  parameter int FLIT_W = 34
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flit_valid_i,
  input  logic [FLIT_W-1:0]     flit_i,
  input  logic [CW-1:0]         cur_x_i,
  input  logic [CW-1:0]         cur_y_i,
  input  logic [CW-1:0]         cur_z_i,
  input  logic [NDIR-1:0]       link_fault_i,
  input  logic [NDIR*NDIR-1:0]  nbr_fault_i,
  output logic                  out_valid_o,
  output logic [PW-1:0]         out_port_o,
  output logic [FLIT_W-1:0]     flit_o,
  output logic                  misroute_o
);
  localparam int NXT_LO = FLIT_W - 2 - PW;
  localparam int DX_LO  = NXT_LO - CW;
  localparam int DY_LO  = DX_LO - CW;
  localparam int DZ_LO  = DY_LO - CW;

  ftype_e          ftype;
  logic            routed;
  coord_t          cur, dst;
  logic [PW-1:0]   carried, sel_port, nxt_port, held_q;
  logic            sel_mis;
  logic [NDIR-1:0] dead;

  always_comb begin
    ftype   = ftype_e'(flit_i[FLIT_W-1 -: 2]);
    routed  = (ftype == FT_HEAD) || (ftype == FT_SINGLE);
    cur.x   = cur_x_i;
    cur.y   = cur_y_i;
    cur.z   = cur_z_i;
    dst.x   = flit_i[DX_LO +: CW];
    dst.y   = flit_i[DY_LO +: CW];
    dst.z   = flit_i[DZ_LO +: CW];
    carried = flit_i[NXT_LO +: PW];
  end

  la_dead_end u_dead (
    .cur_i(cur), .dst_i(dst), .nbr_fault_i(nbr_fault_i), .dead_o(dead)
  );

  la_route_select u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(cur), .dst_i(dst),
    .carried_i(carried), .fault_i(link_fault_i), .dead_i(dead),
    .port_o(sel_port), .misroute_o(sel_mis)
  );

  la_next_hop u_nxt (
    .cur_i(cur), .dst_i(dst), .port_i(sel_port),
    .nbr_fault_i(nbr_fault_i), .next_o(nxt_port)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_port_o  <= PORT_LOCAL;
      flit_o      <= '0;
      misroute_o  <= 1'b0;
      held_q      <= PORT_LOCAL;
    end else begin
      out_valid_o <= flit_valid_i;
      if (flit_valid_i) begin
        out_port_o <= routed ? sel_port : held_q;
        flit_o     <= routed ? {flit_i[FLIT_W-1 -: 2], nxt_port, flit_i[NXT_LO-1:0]}
                             : flit_i;
        misroute_o <= routed & sel_mis;
        if (ftype == FT_HEAD)      held_q <= sel_port;
        else if (ftype == FT_TAIL) held_q <= PORT_LOCAL;
      end
    end
  end

  a_r9_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_i |=> out_valid_o);
  a_r9_idle_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flit_valid_i |=> !out_valid_o);
  a_r2_dest_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_valid_i && routed && cur == dst) |=>
      (out_port_o == PORT_LOCAL && flit_o[NXT_LO +: PW] == PORT_LOCAL));
  a_r8_body_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_valid_i && !routed) |=> (flit_o == $past(flit_i) && !misroute_o));
  a_r6_flag_not_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && misroute_o) |-> out_port_o != PORT_LOCAL);
endmodule

// File: tb/sim_la_route_unit.sv
`timescale 1ns/1ps
module sim_la_route_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flit_valid = 1'b0;
  logic [33:0] flit = '0;
  logic [1:0]  cx = '0, cy = '0, cz = '0;
  logic [5:0]  lf = '0;
  logic [35:0] nbf = '0;
  logic        out_valid, misroute;
  logic [2:0]  out_port;
  logic [33:0] flit_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  la_route_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flit_valid_i(flit_valid), .flit_i(flit),
    .cur_x_i(cx), .cur_y_i(cy), .cur_z_i(cz), .link_fault_i(lf),
    .nbr_fault_i(nbf), .out_valid_o(out_valid), .out_port_o(out_port),
    .flit_o(flit_out), .misroute_o(misroute)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // coordinates packed {z,y,x}
  function automatic logic [5:0] b_min(logic [5:0] c, logic [5:0] d);
    logic [5:0] r;
    for (int a = 0; a < 3; a++) begin
      r[2*a]   = d[2*a +: 2] > c[2*a +: 2];
      r[2*a+1] = d[2*a +: 2] < c[2*a +: 2];
    end
    return r;
  endfunction

  function automatic logic [5:0] b_edge(logic [5:0] c);
    logic [5:0] r;
    for (int a = 0; a < 3; a++) begin
      r[2*a]   = c[2*a +: 2] != 2'd3;
      r[2*a+1] = c[2*a +: 2] != 2'd0;
    end
    return r;
  endfunction

  function automatic logic [5:0] b_mv(logic [5:0] c, int dir);
    logic [5:0] r;
    logic [1:0] v;
    r = c;
    v = c[2*(dir/2) +: 2];
    v = (dir % 2 == 0) ? v + 2'd1 : v - 2'd1;
    r[2*(dir/2) +: 2] = v;
    return r;
  endfunction

  function automatic logic [2:0] b_first(logic [5:0] m);
    for (int i = 0; i < 6; i++) if (m[i]) return 3'(i + 1);
    return 3'd0;
  endfunction

  function automatic logic [5:0] b_hash(int v);
    logic [31:0] x;
    x = 32'(v) * 32'd40503 + 32'd12345;
    x = x ^ (x >> 7);
    return x[5:0] & x[13:8];
  endfunction

  task automatic b_ref(input logic [5:0] c, input logic [5:0] d, input logic [2:0] car,
                       input logic [5:0] f, input logic [35:0] nb,
                       output logic [2:0] port, output logic [2:0] nxt,
                       output logic mis, output string tag);
    logic [5:0] mm, ok, dead, nm, nf, on, n;
    mm = b_min(c, d);
    ok = ~f & b_edge(c);
    for (int i = 0; i < 6; i++) begin
      n = b_mv(c, i);
      dead[i] = (n != d) && ((b_min(n, d) & ~nb[6*i +: 6]) == 6'd0);
    end
    if (c == d) begin port = 3'd0; tag = "R2"; end
    else if (car >= 3'd1 && car <= 3'd6 && ok[car-1] && !dead[car-1]) begin
      port = car; tag = "R3";
    end else if ((mm & ok & ~dead) != 0) begin port = b_first(mm & ok & ~dead); tag = "R4"; end
    else if ((mm & ok) != 0) begin port = b_first(mm & ok); tag = "R5"; end
    else if ((~mm & ok) != 0) begin port = b_first(~mm & ok); tag = "R5"; end
    else begin port = b_first(mm); tag = "R5"; end
    mis = (port != 0) && !mm[port-1];
    if (port == 0) nxt = 3'd0;
    else begin
      n  = b_mv(c, port - 1);
      nf = nb[6*(port-1) +: 6];
      nm = b_min(n, d);
      on = ~nm & ~nf & b_edge(n);
      if (n == d) nxt = 3'd0;
      else if ((nm & ~nf) != 0) nxt = b_first(nm & ~nf);
      else if (on != 0) nxt = b_first(on);
      else nxt = b_first(nm);
    end
  endtask

  function automatic logic [33:0] mk(logic [1:0] t, logic [2:0] car, logic [5:0] d, logic [22:0] pay);
    return {t, car, d[1:0], d[3:2], d[5:4], pay};
  endfunction

  task automatic route_one(input logic [5:0] c, input logic [5:0] d, input logic [2:0] car,
                           input logic [5:0] f, input logic [35:0] nb, input logic [1:0] t);
    logic [2:0] ep, en;
    logic em;
    string tg;
    logic [22:0] pay;
    pay = {c, d, 11'(car * 37 + 5)};
    {cz, cy, cx} = c;
    lf = f; nbf = nb;
    flit = mk(t, car, d, pay);
    flit_valid = 1'b1;
    @(negedge clk);
    b_ref(c, d, car, f, nb, ep, en, em, tg);
    chk(tg, {61'd0, out_port}, {61'd0, ep});
    chk("R6", {63'd0, misroute}, {63'd0, em});
    chk("R7", {30'd0, flit_out}, {30'd0, t, en, d[1:0], d[3:2], d[5:4], pay});
    chk("R9", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic pkt(input logic [1:0] t, input logic [5:0] d, input logic v,
                     input logic [2:0] ep, input string tg);
    flit = mk(t, 3'd0, d, 23'h1234 + 23'(d));
    flit_valid = v;
    @(negedge clk);
    chk(tg, {63'd0, out_valid}, {63'd0, v});
    if (v) begin
      chk(tg, {61'd0, out_port}, {61'd0, ep});
      if (t == 2'b00 || t == 2'b10) begin
        chk("R8", {30'd0, flit_out}, {30'd0, mk(t, 3'd0, d, 23'h1234 + 23'(d))});
        chk("R8", {63'd0, misroute}, 64'd0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {63'd0, out_valid}, 64'd0);
    chk("R1", {63'd0, misroute}, 64'd0);
    chk("R1", {61'd0, out_port}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", {63'd0, out_valid}, 64'd0);
    chk("R1", {61'd0, out_port}, 64'd0);

    // directed corners; cur (1,1,1)=6'b010101, dst (3,2,1)=6'b011011
    route_one(6'b010101, 6'b011011, 3'd3, 6'd0, 36'd0, 2'b01);       // R3 keep north
    route_one(6'b010101, 6'b011011, 3'd5, 6'd0, 36'd0, 2'b01);       // R3 keep detour, R6
    route_one(6'b010101, 6'b011011, 3'd1, 6'd0, 36'h5, 2'b01);       // R4 east nbr dead -> north
    route_one(6'b010101, 6'b011011, 3'd0, 6'd0, 36'd0, 2'b01);       // R4 priority X
    route_one(6'b010101, 6'b011011, 3'd0, 6'b000101, 36'd0, 2'b01);  // R5 detour west, R6
    route_one(6'b010101, 6'b011011, 3'd7, 6'h3F, 36'd0, 2'b11);      // R5 all links faulty
    route_one(6'b010101, 6'b010101, 3'd4, 6'd0, 36'd0, 2'b01);       // R2 at destination
    route_one(6'b000000, 6'b000011, 3'd2, 6'd0, 36'd0, 2'b01);       // R3 reject out-of-mesh west

    // sweeps over all source/destination pairs under four fault maps
    for (int s = 0; s < 4; s++) begin
      for (int ci = 0; ci < 64; ci++) begin
        for (int di = 0; di < 64; di++) begin
          logic [5:0] f;
          logic [35:0] nb;
          f = (s == 0) ? 6'd0 : b_hash(ci + s * 977);
          for (int g = 0; g < 6; g++)
            nb[6*g +: 6] = (s == 0) ? 6'd0 : b_hash(int'(b_mv(6'(ci), g)) + s * 1313 + 4096);
          route_one(6'(ci), 6'(di), 3'((ci + di + s) % 8), f, nb, (di % 2 == 0) ? 2'b01 : 2'b11);
        end
      end
    end

    // R8 packet hold; cur (1,1,1), head to (3,1,1) goes east
    {cz, cy, cx} = 6'b010101;
    lf = '0; nbf = '0;
    pkt(2'b01, 6'b010111, 1'b1, 3'd1, "R8");
    pkt(2'b00, 6'b000000, 1'b1, 3'd1, "R8");
    pkt(2'b10, 6'b000000, 1'b0, 3'd0, "R9");          // invalid tail ignored
    pkt(2'b00, 6'b111111, 1'b1, 3'd1, "R8");
    pkt(2'b11, 6'b010100, 1'b1, 3'd2, "R8");          // single goes west
    pkt(2'b00, 6'b000000, 1'b1, 3'd1, "R8");          // hold untouched by single
    pkt(2'b10, 6'b000000, 1'b1, 3'd1, "R8");          // tail still on held port
    pkt(2'b00, 6'b000000, 1'b1, 3'd0, "R8");          // released to local
    flit_valid = 1'b0;
    @(negedge clk);
    chk("R9", {63'd0, out_valid}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule